// File: doc/BRIEF.md
# Half-Step Clock Ratio Generator

This block turns a 3-bit ratio code into a slower cache-interface clock. The slower clock is described in core-clock terms and needs no second clock domain. Ratios of 1, 1.5, 2, 2.5 and 3 are supported. The fractional ratios need the output edges to fall on the core clock's falling edge, so the block works in half-cycle slots: two slots per core cycle. Each core cycle it reports two things for each half of that cycle: whether an output period starts there, and the level of the divided clock. A later stage can build an actual clock or a pair of edge-qualified enables from these flags.

The applied code is captured on every rising core edge. When the captured code changes, the slot phase restarts and a lock timer begins counting output periods. The ready flag rises once a fixed number of periods have begun. The ready flag drops in the same cycle the input code departs from the captured one, so downstream logic never sees a ready flag tied to the old ratio. Code 000 stops everything. The two codes with no ratio assigned also stop everything and raise an illegal-code flag. All pins are plain control and status levels. The block has no data stream and therefore no handshake.

Top module: `halfstep_ratio_gen`

## Requirements
- R1: With the captured code 000, outputs start_pos, start_neg, level_pos, level_neg and locked stay low, and bad_code is low.
- R2: With the captured code 011 or 111, the clock outputs and locked stay low, and bad_code is high.
- R3: Each code sets the output period length in half core cycles: 001 gives 2, 010 gives 3, 100 gives 4, 101 gives 5 and 110 gives 6. start_pos is high when a period begins at the rising core edge of the cycle. start_neg is high when a period begins at the falling core edge of the cycle.
- R4: In each period the divided clock is high for the first ceil(P/2) half-cycle slots and low for the rest, where P is the period length. level_pos gives the level in the first half of the core cycle and level_neg gives it in the second half.
- R5: After the rising edge that captures a new code, the first output period begins in the rising-edge half of the next core cycle.
- R6: locked rises in the first core cycle after LOCK_PERIODS output periods (default 16) have begun under an unchanged legal nonzero code. It then stays high while the code is held.
- R7: locked is low in any cycle in which ratio_code differs from the code captured at the previous rising edge.
- R8: While rst_n is low, all outputs are low, whatever ratio_code holds.
- R9: start_pos and start_neg are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_code | input | 3 | Ratio selection code |
| start_pos | output | 1 | An output period begins at this cycle's rising core edge |
| start_neg | output | 1 | An output period begins at this cycle's falling core edge |
| level_pos | output | 1 | Divided clock level during the first half of the core cycle |
| level_neg | output | 1 | Divided clock level during the second half of the core cycle |
| locked | output | 1 | Ratio has been stable for LOCK_PERIODS output periods |
| bad_code | output | 1 | Captured code is reserved |

## Verification
The hardest case to reach is a code change while the block is already locked. It needs a long enough run under one ratio for the period count to complete, and then a change whose transition cycle is sampled before the new code is captured. The bench holds each ratio well past its lock point, then drives a new code shortly after a rising edge. It checks that locked is already low at the following falling edge, before any new phase exists. It then follows the restarted phase slot by slot against a model built only on half-slot arithmetic.

// File: rtl/halfstep_pkg.sv
package halfstep_pkg;
  localparam int PH_W = 3;

  typedef enum logic [2:0] {
    RC_STOP  = 3'b000,
    RC_X1    = 3'b001,
    RC_X1P5  = 3'b010,
    RC_RSV_A = 3'b011,
    RC_X2    = 3'b100,
    RC_X2P5  = 3'b101,
    RC_X3    = 3'b110,
    RC_RSV_B = 3'b111
  } ratio_code_e;

  // Period length in half core cycles; zero means stopped.
  function automatic logic [PH_W-1:0] halves_of(input logic [2:0] code);
    case (ratio_code_e'(code))
      RC_X1:   halves_of = PH_W'(2);
      RC_X1P5: halves_of = PH_W'(3);
      RC_X2:   halves_of = PH_W'(4);
      RC_X2P5: halves_of = PH_W'(5);
      RC_X3:   halves_of = PH_W'(6);
      default: halves_of = '0;
    endcase
  endfunction

  function automatic logic is_reserved(input logic [2:0] code);
    return (ratio_code_e'(code) == RC_RSV_A) || (ratio_code_e'(code) == RC_RSV_B);
  endfunction
endpackage

// File: rtl/ratio_capture.sv
module ratio_capture
  import halfstep_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      code_in,
  output logic            changed,
  output logic [PH_W-1:0] halves,
  output logic            run,
  output logic            bad
);
  logic [2:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= 3'b000;
    else        code_q <= code_in;
  end

  always_comb begin
    changed = (code_in != code_q);
    halves  = halves_of(code_q);
    run     = (halves != '0);
    bad     = is_reserved(code_q);
  end

  assert_reserved_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bad |-> !run);
endmodule

// File: rtl/slot_phase.sv
module slot_phase
  import halfstep_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            run,
  input  logic [PH_W-1:0] halves,
  output logic            start_pos,
  output logic            start_neg,
  output logic            level_pos,
  output logic            level_neg
);
  logic [PH_W-1:0] ph, slot1, ph_nxt, hi_len;
  logic [PH_W:0]   s1_sum, n_sum, lim;

  always_comb begin
    lim    = {1'b0, halves};
    s1_sum = {1'b0, ph} + 1'b1;
    slot1  = (s1_sum >= lim) ? PH_W'(s1_sum - lim) : PH_W'(s1_sum);
    n_sum  = {1'b0, slot1} + 1'b1;
    ph_nxt = (n_sum >= lim) ? PH_W'(n_sum - lim) : PH_W'(n_sum);
    hi_len = halves - (halves >> 1);
    start_pos = run && (ph == '0);
    start_neg = run && (slot1 == '0);
    level_pos = run && (ph < hi_len);
    level_neg = run && (slot1 < hi_len);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              ph <= '0;
    else if (restart || !run) ph <= '0;
    else                      ph <= ph_nxt;
  end

  assert_phase_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ph < halves));
  assert_single_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pos && start_neg));
  assert_start_is_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pos |-> level_pos) and (start_neg |-> level_neg));
endmodule

// File: rtl/period_lock.sv
module period_lock #(
  parameter int LOCK_PERIODS = 16,
  localparam int CNT_W = $clog2(LOCK_PERIODS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic changed,
  input  logic run,
  input  logic tick,
  output logic locked
);
  logic [CNT_W-1:0] cnt;
  logic             full;

  assign full   = (cnt == CNT_W'(LOCK_PERIODS));
  assign locked = run && !changed && full;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (changed || !run)  cnt <= '0;
    else if (tick && !full)    cnt <= cnt + 1'b1;
  end

  assert_count_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(LOCK_PERIODS));
  assert_count_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    changed |=> (cnt == '0));
endmodule

// File: rtl/halfstep_ratio_gen.sv
module halfstep_ratio_gen
  import halfstep_pkg::*;
#(
  parameter int LOCK_PERIODS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ratio_code,
  output logic       start_pos,
  output logic       start_neg,
  output logic       level_pos,
  output logic       level_neg,
  output logic       locked,
  output logic       bad_code
);
  logic            changed, run;
  logic [PH_W-1:0] halves;

  ratio_capture u_cap (
    .clk(clk), .rst_n(rst_n), .code_in(ratio_code),
    .changed(changed), .halves(halves), .run(run), .bad(bad_code)
  );

  slot_phase u_phase (
    .clk(clk), .rst_n(rst_n), .restart(changed), .run(run), .halves(halves),
    .start_pos(start_pos), .start_neg(start_neg),
    .level_pos(level_pos), .level_neg(level_neg)
  );

  period_lock #(.LOCK_PERIODS(LOCK_PERIODS)) u_lock (
    .clk(clk), .rst_n(rst_n), .changed(changed), .run(run),
    .tick(start_pos | start_neg), .locked(locked)
  );

  assert_drop_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_code != $past(ratio_code)) |-> !locked);
  assert_stop_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_code == 3'b000 && $past(ratio_code) == 3'b000) |->
      !(start_pos || start_neg || level_pos || level_neg || locked || bad_code));
endmodule

// File: tb/tb_halfstep_ratio_gen.sv
module tb_halfstep_ratio_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ratio_code = 3'b000;
  logic       start_pos, start_neg, level_pos, level_neg, locked, bad_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    logic [5:0] exp;
    logic [5:0] mask;
    int         idx;
  } item_t;
  item_t exp_q[$];

  always #4 clk = ~clk;

  halfstep_ratio_gen dut (
    .clk(clk), .rst_n(rst_n), .ratio_code(ratio_code),
    .start_pos(start_pos), .start_neg(start_neg),
    .level_pos(level_pos), .level_neg(level_neg),
    .locked(locked), .bad_code(bad_code)
  );

  function automatic logic [5:0] got_vec();
    return {start_pos, start_neg, level_pos, level_neg, locked, bad_code};
  endfunction

  // Independent model over half-slot time; bit order {sp,sn,lp,ln,lk,bad}.
  function automatic logic [5:0] model(input logic [2:0] c, input int i);
    int p, h0, h1, hi;
    logic lk;
    case (c)
      3'b001: p = 2; 3'b010: p = 3; 3'b100: p = 4;
      3'b101: p = 5; 3'b110: p = 6; default: p = 0;
    endcase
    if (p == 0) return {5'b0, (c == 3'b011 || c == 3'b111)};
    h0 = (2*i) % p;
    h1 = (2*i + 1) % p;
    hi = (p + 1) / 2;
    lk = (((2*i) + p - 1) / p) >= 16;
    return {h0 == 0, h1 == 0, h0 < hi, h1 < hi, lk, 1'b0};
  endfunction

  function automatic string tag_for(input logic [5:0] d, input logic [2:0] c, input int idx);
    if (idx < 0)                   return "R7";
    if (c == 3'b000)               return "R1";
    if (c == 3'b011 || c == 3'b111) return "R2";
    if (d[1])                      return "R6";
    if (idx == 0)                  return "R5";
    if (d[5] || d[4])              return "R3";
    return "R4";
  endfunction

  logic [2:0] cur_code = 3'b000;

  // Driver: apply a code just after a rising edge and queue expectations.
  task automatic drive(input logic [2:0] c, input int n);
    item_t it;
    #1 ratio_code = c;
    cur_code = c;
    it.exp = 6'b0; it.mask = 6'b000010; it.idx = -1;  // R7 transition cycle
    exp_q.push_back(it);
    for (int i = 0; i < n; i++) begin
      it.exp = model(c, i); it.mask = 6'b111111; it.idx = i;
      exp_q.push_back(it);
    end
    repeat (n + 1) @(posedge clk);
  endtask

  // Monitor: compare at every falling edge while items are queued.
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      item_t it;
      logic [5:0] g, d;
      it = exp_q.pop_front();
      g = got_vec();
      d = (g ^ it.exp) & it.mask;
      n_checks++;
      if (d != 6'b0) begin
        n_fail++;
        $display("FAIL %s code=%b idx=%0d got=%b expected=%b",
                 tag_for(d, cur_code, it.idx), cur_code, it.idx, g & it.mask, it.exp & it.mask);
      end
    end
  end

  initial begin
    ratio_code = 3'b101;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;  // R8 reset state
    if (got_vec() != 6'b0) begin
      n_fail++;
      $display("FAIL R8 got=%b expected=%b", got_vec(), 6'b0);
    end
    @(posedge clk);
    #1 ratio_code = 3'b000;
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    drive(3'b001, 40);   // R3 R4 R5 R6
    drive(3'b010, 40);   // R7 from locked state
    drive(3'b100, 45);
    drive(3'b101, 50);
    drive(3'b110, 55);
    drive(3'b011, 10);   // R2
    drive(3'b000, 10);   // R1
    drive(3'b111, 10);   // R2
    drive(3'b010, 30);
    drive(3'b110, 20);   // change before lock completes
    drive(3'b001, 20);
    drive(3'b101, 60);   // R9 across a long run
    drive(3'b000, 5);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired got=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule